// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block computes the memory address for a load or store in a RISC pipeline and, where the addressing form asks for it, the updated base register value with a write enable for the register file. It takes a base register value, the program counter, an offset that is either a signed immediate from the instruction or a register value passed through a logical shifter, and a two-bit addressing form select.

Four addressing forms are supported. Offset-before-access, which leaves the base untouched. Offset-before-access with update, where the same sum is both the address and the new base. Offset-after-access, where the raw base goes to memory while base plus offset goes back to the register. Program-counter-relative, which adds the immediate to the PC. A register offset is treated as a magnitude, and an up/down bit picks whether it is added or subtracted.

All inputs are captured on a valid strobe. The results appear one clock later, together with a matching valid output.

Top module: `ldst_agu`

## Requirements
- R1: With mode = 2'b00 (offset-before-access), the address is base + offset, wb_en is 0 and new_base equals the input base.
- R2: With mode = 2'b01 (offset-before-access with update), the address and new_base both equal base + offset and wb_en is 1.
- R3: With mode = 2'b10 (offset-after-access), the address equals the unmodified input base, new_base equals base + offset and wb_en is 1.
- R4: When use_reg = 1, the offset magnitude is reg_off shifted logically by sh_amt (0 to 31). The shift is left when sh_right = 0 and right when sh_right = 1, with zeros filled in.
- R5: When use_reg = 1, the shifted magnitude is added to the base when add_up = 1 and subtracted from it when add_up = 0.
- R6: When use_reg = 0, the offset is imm (IMMW bits, two's complement) sign-extended to the address width and added to the base. In this case add_up, sh_right and sh_amt have no effect.
- R7: With mode = 2'b11 (PC-relative), the address is pc + sign-extended imm and wb_en is 0. new_base equals the input base. use_reg, reg_off, add_up and the shift controls have no effect in this mode.
- R8: All sums and differences wrap modulo 2^AW.
- R9: Outputs update on the clock edge that samples in_valid = 1, and out_valid then equals the in_valid sampled on that edge. When in_valid = 0, addr, new_base and wb_en keep their previous values.
- R10: While rst_n = 0, out_valid, addr, new_base and wb_en are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe for the request |
| mode | input | 2 | Addressing form: 00 pre, 01 pre with update, 10 post, 11 PC-relative |
| use_reg | input | 1 | 1 selects the shifted register offset, 0 selects the immediate |
| base | input | AW | Base register value |
| pc | input | AW | Program counter |
| imm | input | IMMW | Signed immediate offset |
| reg_off | input | AW | Register offset magnitude |
| sh_right | input | 1 | Shift direction for reg_off: 0 left, 1 right |
| sh_amt | input | SHW | Shift amount |
| add_up | input | 1 | 1 adds the register offset, 0 subtracts it |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| addr | output | AW | Effective memory address |
| new_base | output | AW | Base value to write back |
| wb_en | output | 1 | Write-back enable for new_base |

## Verification
The hardest case to produce at the ports is one where an ignored control could leak into the result. Examples are a set add_up bit or a large shift on an immediate-offset or PC-relative request, or a subtracted register offset that must wrap below zero. Random stimulus seldom lines these up with telling operand values. The directed vectors therefore set the ignored controls to their most damaging values: subtract, shift 31 and a nonzero reg_off. They pair these with operands chosen so that any leak changes the address. They also place shifts of 0 and 31 in both directions against base values near both ends of the address range. Idle cycles are mixed in so that the hold behaviour is compared on every clock.

// File: rtl/ldst_agu.sv
module ldst_agu #(
  parameter int AW   = 32,
  parameter int IMMW = 12,
  parameter int SHW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      mode,
  input  logic            use_reg,
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   pc,
  input  logic [IMMW-1:0] imm,
  input  logic [AW-1:0]   reg_off,
  input  logic            sh_right,
  input  logic [SHW-1:0]  sh_amt,
  input  logic            add_up,
  output logic            out_valid,
  output logic [AW-1:0]   addr,
  output logic [AW-1:0]   new_base,
  output logic            wb_en
);
  localparam logic [1:0] M_PRE   = 2'b00;
  localparam logic [1:0] M_PREWB = 2'b01;
  localparam logic [1:0] M_POST  = 2'b10;
  localparam logic [1:0] M_REL   = 2'b11;

  wire            pcrel   = (mode == M_REL);
  wire            reg_src = use_reg && !pcrel;
  wire [AW-1:0]   imm_x   = {{(AW-IMMW){imm[IMMW-1]}}, imm};
  wire [AW-1:0]   shifted = sh_right ? (reg_off >> sh_amt) : (reg_off << sh_amt);
  wire [AW-1:0]   mag     = reg_src ? shifted : imm_x;
  wire [AW-1:0]   origin  = pcrel ? pc : base;
  wire [AW-1:0]   sum     = (reg_src && !add_up) ? origin - mag : origin + mag;
  wire            wb_d    = (mode == M_PREWB) || (mode == M_POST);
  wire [AW-1:0]   addr_d  = (mode == M_POST) ? base : sum;
  wire [AW-1:0]   nb_d    = wb_d ? sum : base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      addr      <= '0;
      new_base  <= '0;
      wb_en     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        addr     <= addr_d;
        new_base <= nb_d;
        wb_en    <= wb_d;
      end
    end
  end

  wire unused_pre = (M_PRE == mode);
  logic unused_sink;
  assign unused_sink = unused_pre;
endmodule

// File: rtl/ldst_agu_chk.sv
module ldst_agu_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    mode,
  input logic [AW-1:0] base,
  input logic          out_valid,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] new_base,
  input logic          wb_en
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(addr) && $stable(new_base) && $stable(wb_en)));
  a_r1_pre_keeps_base: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00) |=> (!wb_en && new_base == $past(base)));
  a_r2_prewb_same: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b01) |=> (wb_en && addr == new_base));
  a_r3_post_raw_base: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10) |=> (wb_en && addr == $past(base)));
  a_r7_rel_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11) |=> (!wb_en && new_base == $past(base)));
  a_r10_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && addr == '0 && new_base == '0 && !wb_en));
endmodule

bind ldst_agu ldst_agu_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .base(base),
  .out_valid(out_valid), .addr(addr), .new_base(new_base), .wb_en(wb_en)
);

// File: tb/ldst_agu_tb.sv
`timescale 1ns/1ps
module ldst_agu_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  mode;
  logic        use_reg;
  logic [31:0] base, pc, reg_off;
  logic [11:0] imm;
  logic        sh_right, add_up;
  logic [4:0]  sh_amt;
  logic        out_valid, wb_en;
  logic [31:0] addr, new_base;

  always #2 clk = ~clk;

  ldst_agu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .use_reg(use_reg),
    .base(base), .pc(pc), .imm(imm), .reg_off(reg_off), .sh_right(sh_right),
    .sh_amt(sh_amt), .add_up(add_up), .out_valid(out_valid), .addr(addr),
    .new_base(new_base), .wb_en(wb_en)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  logic        e_valid = 0, e_wb = 0;
  logic [31:0] e_addr = 0, e_nb = 0;
  string       e_tag = "R10";

  task automatic cmp(string what, longint act, longint exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", e_tag, what, act, exp);
    end
  endtask

  task automatic compare_now();
    vectors++;
    cmp("out_valid", out_valid, e_valid);
    cmp("addr", addr, e_addr);
    cmp("new_base", new_base, e_nb);
    cmp("wb_en", wb_en, e_wb);
  endtask

  task automatic apply(string tag, bit v, bit [1:0] m, bit ur, bit [31:0] b,
                       bit [31:0] p, bit [11:0] i, bit [31:0] r, bit dir,
                       bit [4:0] amt, bit up);
    longint off, org, s, pw;
    @(negedge clk);
    compare_now();
    in_valid = v; mode = m; use_reg = ur; base = b; pc = p; imm = i;
    reg_off = r; sh_right = dir; sh_amt = amt; add_up = up;
    e_valid = v;
    if (!v) begin
      e_tag = "R9";
      return;
    end
    e_tag = tag;
    pw = 1;
    for (int k = 0; k < amt; k++) pw = pw * 2;
    if (ur && m != 2'd3) begin
      off = dir ? (longint'(r) / pw) : ((longint'(r) * pw) % 64'h1_0000_0000);
      if (!up) off = -off;
    end else begin
      off = i;
      if (i[11]) off = off - 4096;
    end
    org = (m == 2'd3) ? longint'(p) : longint'(b);
    s = (org + off) & 64'hFFFF_FFFF;
    case (m)
      2'd0: begin e_addr = s[31:0]; e_nb = b; e_wb = 0; end
      2'd1: begin e_addr = s[31:0]; e_nb = s[31:0]; e_wb = 1; end
      2'd2: begin e_addr = b; e_nb = s[31:0]; e_wb = 1; end
      default: begin e_addr = s[31:0]; e_nb = b; e_wb = 0; end
    endcase
  endtask

  initial begin
    rst_n = 0; in_valid = 0; mode = 0; use_reg = 0; base = 0; pc = 0; imm = 0;
    reg_off = 0; sh_right = 0; sh_amt = 0; add_up = 0;
    repeat (3) @(negedge clk);
    e_tag = "R10";
    compare_now();
    rst_n = 1;
    apply("R1", 1, 2'd0, 0, 32'h0000_1000, 0, 12'h010, 32'hDEAD_BEEF, 1, 31, 0);
    apply("R2", 1, 2'd1, 0, 32'h0000_1000, 0, 12'hFF0, 0, 0, 0, 1);
    apply("R3", 1, 2'd2, 1, 32'h0000_2000, 0, 0, 32'h4, 0, 2, 1);
    apply("R4", 1, 2'd0, 1, 32'h100, 0, 0, 32'h8000_0001, 0, 0, 1);
    apply("R4", 1, 2'd0, 1, 32'h100, 0, 0, 32'h8000_0001, 1, 0, 1);
    apply("R4", 1, 2'd1, 1, 32'h100, 0, 0, 32'h0000_0003, 0, 31, 1);
    apply("R4", 1, 2'd2, 1, 32'h100, 0, 0, 32'hF000_0000, 1, 31, 1);
    apply("R9", 0, 2'd1, 1, 32'h5555_5555, 0, 0, 32'h1234, 0, 3, 1);
    apply("R9", 0, 2'd3, 0, 32'hAAAA_AAAA, 32'h1, 12'h7FF, 0, 0, 0, 0);
    apply("R5", 1, 2'd1, 1, 32'h10, 0, 0, 32'h20, 0, 0, 0);
    apply("R5", 1, 2'd0, 1, 32'h1000, 0, 0, 32'h1, 0, 4, 0);
    apply("R6", 1, 2'd0, 0, 32'h8000, 0, 12'h800, 32'hFFFF_FFFF, 1, 31, 0);
    apply("R6", 1, 2'd2, 0, 32'h8000, 0, 12'h7FF, 32'hFFFF_FFFF, 0, 17, 0);
    apply("R7", 1, 2'd3, 1, 32'h4000, 32'h0000_0800, 12'hFFC, 32'h1000, 1, 3, 0);
    apply("R7", 1, 2'd3, 1, 32'h4000, 32'h0000_0800, 12'h004, 32'h1000, 0, 31, 0);
    apply("R8", 1, 2'd1, 1, 32'hFFFF_FFF0, 0, 0, 32'h20, 0, 0, 1);
    apply("R8", 1, 2'd2, 0, 32'h0000_0004, 0, 12'hFF0, 0, 0, 0, 0);
    apply("R8", 1, 2'd3, 0, 0, 32'hFFFF_FFFE, 12'h004, 0, 0, 0, 1);
    for (int n = 0; n < 3000; n++) begin
      bit [1:0] m = 2'($urandom_range(0, 3));
      string t;
      case (m) 2'd0: t = "R1"; 2'd1: t = "R2"; 2'd2: t = "R3"; default: t = "R7"; endcase
      apply(t, ($urandom_range(0, 7) != 0), m, 1'($urandom), $urandom, $urandom,
            12'($urandom), $urandom, 1'($urandom),
            (n % 8 == 0) ? 5'd31 : (n % 8 == 1) ? 5'd0 : 5'($urandom), 1'($urandom));
    end
    @(negedge clk);
    compare_now();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule